// File: doc/BRIEF.md
# Raster timing generator with post-reset register warm-up gate

This block produces the scan position of a video frame of 262 lines of 341 dots each. It is clocked at the dot rate, which runs at three times the processor rate, and it receives a one-clock enable marking each processor cycle. From the scan position it keeps a vertical-blank flag. The flag sets when line 241 begins and clears again when the final, pre-render line begins. An interrupt request is raised while the flag is set and software has enabled it. One frame therefore lasts roughly 29781 processor cycles.

The block also owns the small processor-facing register bank of the video unit, with two exceptions in behaviour after a reset. For a fixed number of processor cycles, writes to the control register and to the video-memory address register are dropped. During almost the same window, reads of the data port fill the internal read-ahead buffer with zero rather than with memory contents. Writes to the data port and to the object-memory pointer and data registers work at once. The video-memory address is kept across a warm reset. A cold reset (power-up) leaves the blank flag set. A warm reset leaves it clear, and it next sets when the scan reaches the blank line.

Top module: `vtiming_gate`

## Requirements
- R1: `dot` counts 0 to DOTS-1 on every clock and then wraps to 0. `line` advances by one on each wrap and itself wraps from LINES-1 to 0.
- R2: A reset cycle places the scan position at dot RST_DOT of line RST_LINE. Counting starts from there on the first clock without reset.
- R3: The blank flag sets on the clock where the scan sits at dot 1 of line VBL_LINE. It clears on the clock where the scan sits at dot 1 of line LINES-1. The flag is bit 7 of the status register (register index 2), and the other status bits read 0.
- R4: Reset with `cold` high leaves the blank flag set. Reset with `cold` low leaves it clear.
- R5: A status read clears the blank flag. It also returns the address register's two-write sequence to its high-byte step.
- R6: `nmi` is high exactly while the blank flag and the interrupt enable (bit 7 of control register index 0) are both set. It updates on the same clock as either of them.
- R7: After reset a counter counts `cpu_ce` pulses and saturates at WR_WARMUP. Writes to control (index 0) and to the address register (index 6) made while the count is below WR_WARMUP change nothing, including the two-write step.
- R8: A data-port read (index 7) returns the read-ahead buffer. It then reloads the buffer, with zero while the count is below RD_WARMUP and with memory at the current address otherwise. The address then advances by 1, or by 32 when control bit 2 is set.
- R9: Data-port writes store at the current address and advance it the same way. Object pointer (index 3) and object data (index 4) writes are taken at any time, and each object data write advances the pointer. The video-memory address is not changed by a reset.
- R10: Register accesses take effect only on clocks with `cpu_ce` high. `reg_rdata` is registered and holds the result from that clock on. Object data reads return object memory at the pointer, and reads of any other index return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cold | input | 1 | Sampled during reset: high marks a power-up |
| cpu_ce | input | 1 | One-clock pulse per processor cycle |
| reg_addr | input | 3 | Register index |
| reg_rd | input | 1 | Read strobe, used with `cpu_ce` |
| reg_wr | input | 1 | Write strobe, used with `cpu_ce` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| nmi | output | 1 | Interrupt request |
| dot | output | DOT_W (9) | Dot position within the line |
| line | output | LINE_W (9) | Line position within the frame |

## Verification
The bench builds the block with a 20-dot, 12-line frame and blank line 9. It uses a start dot of 3 and warm-up thresholds of 40 (writes) and 39 (reads), keeping default memory sizes. This brings frame wraps, repeated flag set and clear, and both threshold edges within a few hundred processor cycles. A read just below, at, and just above the read threshold and an ignored control write one cycle before the write threshold can therefore be placed exactly.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_OBJA = 3'd3;
  localparam logic [2:0] RA_OBJD = 3'd4;
  localparam logic [2:0] RA_VADR = 3'd6;
  localparam logic [2:0] RA_DATA = 3'd7;
  localparam int CTRL_NMI_BIT = 7;
  localparam int CTRL_INC_BIT = 2;
  localparam int BYTE_W       = 8;
  localparam int STRIDE_WIDE  = 32;
endpackage

// File: rtl/vtg_raster.sv
module vtg_raster #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  parameter int RST_DOT  = 23,
  parameter int RST_LINE = 0,
  localparam int DW = $clog2(DOTS),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          vbl_set,
  output logic          vbl_clr
);
  logic at_end;
  assign at_end = (dot == DW'(DOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dot  <= DW'(RST_DOT);
      line <= LW'(RST_LINE);
    end else if (at_end) begin
      dot  <= '0;
      line <= (line == LW'(LINES - 1)) ? '0 : line + 1'b1;
    end else begin
      dot <= dot + 1'b1;
    end
  end

  assign vbl_set = (line == LW'(VBL_LINE))  && (dot == DW'(1));
  assign vbl_clr = (line == LW'(LINES - 1)) && (dot == DW'(1));

  // R1
  dot_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(dot) < DOTS) && (int'(line) < LINES));
  // R1
  dot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (dot == '0));
  // R1
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !at_end |=> $stable(line));
endmodule

// File: rtl/vtg_warmup.sv
module vtg_warmup #(
  parameter int WR_WARMUP = 29658,
  parameter int RD_WARMUP = 29657,
  localparam int CW = $clog2(WR_WARMUP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  output logic wr_ok,
  output logic rd_ok
);
  logic [CW-1:0] cnt;

  assign wr_ok = (cnt >= CW'(WR_WARMUP));
  assign rd_ok = (cnt >= CW'(RD_WARMUP));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (ce && !wr_ok) cnt <= cnt + 1'b1;
  end

  // R7
  wr_ok_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> wr_ok);
  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= WR_WARMUP);
  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(cnt));
endmodule

// File: rtl/vtg_ram.sv
module vtg_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vtiming_gate.sv
module vtiming_gate
  import vtg_pkg::*;
#(
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VBL_LINE  = 241,
  parameter int RST_DOT   = 23,
  parameter int RST_LINE  = 0,
  parameter int WR_WARMUP = 29658,
  parameter int RD_WARMUP = 29657,
  parameter int ADDR_W    = 10,
  parameter int OAM_AW    = 8,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cold,
  input  logic              cpu_ce,
  input  logic [2:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              nmi,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line
);
  logic at_set, at_clr, wr_ok, rd_ok;

  vtg_raster #(
    .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE),
    .RST_DOT(RST_DOT), .RST_LINE(RST_LINE)
  ) u_raster (
    .clk(clk), .rst(rst), .dot(dot), .line(line),
    .vbl_set(at_set), .vbl_clr(at_clr)
  );

  vtg_warmup #(.WR_WARMUP(WR_WARMUP), .RD_WARMUP(RD_WARMUP)) u_warm (
    .clk(clk), .rst(rst), .ce(cpu_ce), .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  logic acc_wr, acc_rd;
  logic wr_ctrl, wr_vadr, wr_data, wr_obja, wr_objd, rd_stat, rd_data;
  assign acc_wr  = cpu_ce && reg_wr;
  assign acc_rd  = cpu_ce && reg_rd && !reg_wr;
  assign wr_ctrl = acc_wr && (reg_addr == RA_CTRL) && wr_ok;
  assign wr_vadr = acc_wr && (reg_addr == RA_VADR) && wr_ok;
  assign wr_data = acc_wr && (reg_addr == RA_DATA);
  assign wr_obja = acc_wr && (reg_addr == RA_OBJA);
  assign wr_objd = acc_wr && (reg_addr == RA_OBJD);
  assign rd_stat = acc_rd && (reg_addr == RA_STAT);
  assign rd_data = acc_rd && (reg_addr == RA_DATA);

  logic              nmi_en, inc32, vbl_q, wtog;
  logic              vbl_n, nmi_en_n;
  logic [ADDR_W-1:0] vaddr, vstep;
  logic [OAM_AW-1:0] obj_addr;
  logic [7:0]        rdbuf, vram_q, oam_q, rd_mux;

  vtg_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_vram (
    .clk(clk), .we(wr_data), .waddr(vaddr), .wdata(reg_wdata),
    .raddr(vaddr), .rdata(vram_q)
  );

  vtg_ram #(.AW(OAM_AW), .DW(BYTE_W)) u_oam (
    .clk(clk), .we(wr_objd), .waddr(obj_addr), .wdata(reg_wdata),
    .raddr(obj_addr), .rdata(oam_q)
  );

  always_comb begin
    if (at_set)       vbl_n = 1'b1;
    else if (at_clr)  vbl_n = 1'b0;
    else if (rd_stat) vbl_n = 1'b0;
    else              vbl_n = vbl_q;
    nmi_en_n = wr_ctrl ? reg_wdata[CTRL_NMI_BIT] : nmi_en;
  end

  always_comb begin
    case (reg_addr)
      RA_STAT: rd_mux = {vbl_q, 7'b0};
      RA_OBJD: rd_mux = oam_q;
      RA_DATA: rd_mux = rdbuf;
      default: rd_mux = 8'h00;
    endcase
  end

  assign vstep = inc32 ? ADDR_W'(STRIDE_WIDE) : ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_en    <= 1'b0;
      inc32     <= 1'b0;
      vbl_q     <= cold;
      nmi       <= 1'b0;
      wtog      <= 1'b0;
      obj_addr  <= '0;
      rdbuf     <= '0;
      reg_rdata <= '0;
    end else begin
      vbl_q  <= vbl_n;
      nmi_en <= nmi_en_n;
      nmi    <= vbl_n && nmi_en_n;
      if (wr_ctrl) inc32 <= reg_wdata[CTRL_INC_BIT];
      if (rd_stat)      wtog <= 1'b0;
      else if (wr_vadr) wtog <= ~wtog;
      if (wr_obja)      obj_addr <= reg_wdata[OAM_AW-1:0];
      else if (wr_objd) obj_addr <= obj_addr + 1'b1;
      if (rd_data) rdbuf <= rd_ok ? vram_q : 8'h00;
      if (acc_rd)  reg_rdata <= rd_mux;
    end
  end

  // address register has no reset so it survives a warm reset
  always_ff @(posedge clk) begin
    if (wr_vadr && !wtog)      vaddr <= {reg_wdata[ADDR_W-9:0], vaddr[7:0]};
    else if (wr_vadr)          vaddr <= {vaddr[ADDR_W-1:8], reg_wdata};
    else if (wr_data || rd_data) vaddr <= vaddr + vstep;
  end

  // R3
  vbl_set_chk: assert property (@(posedge clk) disable iff (rst)
    at_set |=> vbl_q);
  // R5
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !at_set) |=> !vbl_q);
  // R6
  nmi_gate_chk: assert property (@(posedge clk) disable iff (rst)
    nmi |-> (vbl_q && nmi_en));
  // R7
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && (reg_addr == RA_CTRL) && !wr_ok) |=> ($stable(nmi_en) && $stable(inc32)));
  // R8
  zero_load_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rd_ok) |=> (rdbuf == 8'h00));
endmodule

// File: tb/vtiming_gate_tb.sv
module vtiming_gate_tb;
  localparam int D = 20, L = 12, VL = 9, RD0 = 3, RL0 = 0;
  localparam int WR = 40, RDW = 39, AW = 10;

  logic clk = 0, rst = 1, cold = 1, ce = 0, rd = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic nmi;
  logic [4:0] dot;
  logic [3:0] line;

  vtiming_gate #(.DOTS(D), .LINES(L), .VBL_LINE(VL), .RST_DOT(RD0), .RST_LINE(RL0),
    .WR_WARMUP(WR), .RD_WARMUP(RDW), .ADDR_W(AW), .OAM_AW(8)) u_dut (
    .clk(clk), .rst(rst), .cold(cold), .cpu_ce(ce), .reg_addr(addr), .reg_rd(rd),
    .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata), .nmi(nmi), .dot(dot), .line(line));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, clks = 0, ncyc = 0;
  logic mvbl = 0, men = 0, started = 0, done = 0;
  logic [7:0] last_rd;
  logic [7:0] shadow [1024];

  function automatic int pos_of(input int n);
    return (RL0 * D + RD0 + n) % (D * L);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // requirement model of blank flag, enable and warm-up count
  always @(posedge clk) begin
    int p;
    if (rst) begin
      clks <= 0; ncyc <= 0; mvbl <= cold; men <= 0;
    end else begin
      p = pos_of(clks);
      clks <= clks + 1;
      if (p == VL * D + 1) mvbl <= 1;
      else if (p == (L - 1) * D + 1) mvbl <= 0;
      else if (ce && rd && !wr && addr == 3'd2) mvbl <= 0;
      if (ce && wr && addr == 3'd0 && ncyc >= WR) men <= wdata[7];
      if (ce && ncyc < WR) ncyc <= ncyc + 1;
    end
  end

  // R1 R2 R6: scan position and interrupt line on every clock
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R1 dot", int'(dot), pos_of(clks) % D);
      chk("R1 line", int'(line), pos_of(clks) / D);
      chk("R6 nmi", int'(nmi), int'(mvbl && men));
    end
  end

  task automatic cyc(input logic [2:0] a, input logic r, input logic w, input logic [7:0] d);
    addr = a; rd = r; wr = w; wdata = d; ce = 1;
    @(negedge clk);
    last_rd = rdata;
    ce = 0; rd = 0; wr = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(); cyc(3'd0, 0, 0, 8'h00); endtask
  task automatic wrreg(input logic [2:0] a, input logic [7:0] d); cyc(a, 0, 1, d); endtask
  task automatic rdreg(input logic [2:0] a); cyc(a, 1, 0, 8'h00); endtask
  task automatic setva(input logic [9:0] v);
    wrreg(3'd6, {6'b0, v[9:8]});
    wrreg(3'd6, v[7:0]);
  endtask
  task automatic wrdata(input logic [9:0] at, input logic [7:0] d);
    wrreg(3'd7, d); shadow[at] = d;
  endtask
  task automatic rdstat(input string req);
    logic [7:0] e;
    e = {mvbl, 7'b0};
    rdreg(3'd2);
    chk(req, int'(last_rd), int'(e));
  endtask
  task automatic do_reset(input logic c);
    @(negedge clk);
    rst = 1; cold = c;
    repeat (2) @(negedge clk);
    rst = 0;
    started = 1;
  endtask
  task automatic wait_vbl(input logic lvl);
    int k;
    k = 0;
    while (mvbl != lvl && k < 500) begin idle(); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 1024; i++) shadow[i] = 8'h00;
    @(negedge clk);
    do_reset(1);
    // R2 start position
    chk("R2 dot", int'(dot), RD0);
    chk("R2 line", int'(line), RL0);
    rdreg(3'd2); chk("R4 cold status", int'(last_rd), 8'h80);
    rdreg(3'd2); chk("R5 status cleared", int'(last_rd), 8'h00);
    wrreg(3'd3, 8'h05);
    wrreg(3'd4, 8'hA5);
    wrreg(3'd0, 8'h80);
    while (ncyc < WR - 1) idle();
    wrreg(3'd0, 8'h80);
    wait_vbl(1);
    idle();
    chk("R7 early enable ignored", int'(nmi), 0);
    wrreg(3'd0, 8'h80);
    chk("R6 nmi raised", int'(nmi), 1);
    rdreg(3'd2); chk("R3 flag set", int'(last_rd), 8'h80);
    chk("R5 nmi dropped by status read", int'(nmi), 0);
    wait_vbl(1);
    chk("R6 nmi at next frame", int'(nmi), 1);
    wait_vbl(0);
    chk("R3 nmi after auto clear", int'(nmi), 0);
    rdreg(3'd2); chk("R3 flag auto cleared", int'(last_rd), 8'h00);
    wrreg(3'd0, 8'h00);
    wrreg(3'd3, 8'h05);
    rdreg(3'd4); chk("R9 early object write kept", int'(last_rd), 8'hA5);
    rdreg(3'd1); chk("R10 unmapped 1", int'(last_rd), 0);
    rdreg(3'd5); chk("R10 unmapped 5", int'(last_rd), 0);
    rdreg(3'd0); chk("R10 control reads 0", int'(last_rd), 0);

    setva(10'h014);
    wrdata(10'h014, 8'h55); wrdata(10'h015, 8'h66);
    wrdata(10'h016, 8'h77); wrdata(10'h017, 8'h88);
    setva(10'h030); wrdata(10'h030, 8'hEE);
    setva(10'h013);

    do_reset(0);
    rdreg(3'd2); chk("R4 warm status", int'(last_rd), 8'h00);
    wrdata(10'h013, 8'h44);
    setva(10'h030);
    rdreg(3'd7);
    rdreg(3'd7); chk("R8 early read gives zero", int'(last_rd), 0);
    while (ncyc < RDW - 1) idle();
    rdreg(3'd7);
    rdreg(3'd7); chk("R8 read at threshold returns zero", int'(last_rd), 0);
    rdreg(3'd7); chk("R8 R7 first normal load, address write ignored", int'(last_rd), 8'h88);
    setva(10'h013);
    rdreg(3'd7);
    rdreg(3'd7); chk("R9 address survived, data write accepted", int'(last_rd), 8'h44);

    wrreg(3'd0, 8'h04);
    setva(10'h002);
    wrdata(10'h002, 8'hB0);
    wrdata(10'h022, 8'hB1);
    wrreg(3'd0, 8'h00);
    setva(10'h022); rdreg(3'd7); rdreg(3'd7);
    chk("R8 stride 32", int'(last_rd), 8'hB1);
    setva(10'h002); rdreg(3'd7); rdreg(3'd7);
    chk("R8 stride 32 first", int'(last_rd), 8'hB0);

    wrreg(3'd6, 8'h00);
    rdstat("R3 status");
    setva(10'h022); rdreg(3'd7); rdreg(3'd7);
    chk("R5 write step reset", int'(last_rd), 8'hB1);

    for (int i = 0; i < 24; i++) begin
      logic [9:0] a;
      logic [7:0] d;
      a = 10'($urandom % 1024);
      d = 8'($urandom % 256);
      wrreg(3'd0, 8'($urandom) & 8'h84);
      setva(a);
      wrdata(a, d);
      setva(a);
      rdreg(3'd7); rdreg(3'd7);
      chk("R8 random readback", int'(last_rd), int'(shadow[a]));
      rdstat("R3 random status");
      repeat ($urandom % 8) idle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule